// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets on-chip logic read and write single bytes in an external asynchronous static RAM with a 20-bit address and an 8-bit data path. A requester raises a request with a direction flag, an address and, for writes, a byte. The controller drives the memory's two chip selects, its output enable and its write enable, and gets one acknowledge cycle back when the access is complete. One select is active-low and the other active-high, and the memory responds only while both are asserted. On a read, the captured byte is presented together with the acknowledge.

Every memory timing figure is a parameter in nanoseconds, and so is the system clock period. Each phase length is derived at elaboration as a whole number of clock cycles, so the same RTL meets the memory's limits at any clock rate. The shared data bus is split into an outgoing byte, an incoming byte and a drive-enable that feeds the pad tri-state buffer. The controller drives the bus only while a write is in progress. After a read, it waits for the memory to release the bus before it drives it again.

Top module: `sram_port_ctrl`

## Requirements
- R1: While reset is asserted, mem_sel_n is 1, mem_sel is 0, mem_oe_n is 1, mem_we_n is 1, mem_dq_oe is 0 and ack is 0.
- R2: With no request pending, the memory is in standby: mem_sel_n is 1, mem_sel is 0, mem_oe_n is 1, mem_we_n is 1 and mem_dq_oe is 0.
- R3: A read accepted at clock edge A holds mem_sel_n=0, mem_sel=1, mem_oe_n=0, mem_we_n=1 and mem_dq_oe=0 for N_RD cycles after A. N_RD is the larger of ceil(T_AA_NS/CLK_NS) and ceil(T_RC_NS/CLK_NS).
- R4: rd_data takes the value on mem_dq_in at the last edge of the read phase, and it is valid in the cycle where ack is 1.
- R5: A write accepted at edge A gives one setup cycle, in which the selects are active, the address and data are driven and mem_we_n is 1. mem_we_n is then 0 for N_PW cycles, the largest of the write-pulse, address-to-end and data-setup times in cycles.
- R6: mem_dq_oe is 1 with mem_dq_out equal to the request byte through every write cycle, including the cycle after mem_we_n rises. It is 0 at all other times. mem_oe_n stays 1 throughout a write.
- R7: After mem_we_n rises, the selects and data stay active for N_WH cycles. N_WH is the larger of ceil(T_HD_NS/CLK_NS) (at least 1) and ceil(T_WC_NS/CLK_NS)-1-N_PW.
- R8: ack is 1 for exactly the one cycle after the final phase edge, when the selects are already inactive. A request still high in that cycle is not accepted again.
- R9: mem_dq_oe does not rise within ceil(T_HZ_NS/CLK_NS) cycles after mem_oe_n rises at the end of a read. A write that follows a read waits for this interval.
- R10: mem_addr holds the request address and stays unchanged for as long as the selects are active.
- R11: Each phase length is a required time divided by CLK_NS and rounded up, so a fractional cycle always adds a full cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request pending, held until ack |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 20 | Byte address of the request |
| req_wdata | input | 8 | Byte to write |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte read, valid with ack |
| mem_addr | output | 20 | Memory address pins |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 8 | Byte driven onto the data bus |
| mem_dq_oe | output | 1 | Drive enable of the data bus tri-state |
| mem_dq_in | input | 8 | Byte sampled from the data bus |

## Verification
The bench runs a 4 ns clock with the write cycle time raised to 80 ns and all other timing at its defaults. This gives a 14-cycle read phase, a 12-cycle write pulse set by the 45 ns address-to-end limit rather than the 40 ns pulse width, and a 5-cycle bus turnaround. The raised cycle time stretches the write hold phase to 7 cycles, so the padding term of the hold length is used instead of the minimum-one hold. The memory model returns garbage until the access time has elapsed in whole cycles and measures the pulse, setup, select-window and bus-release intervals in nanoseconds. A phase that is one cycle too short is therefore caught at the rounded boundary.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_HOLD,
    ST_RD_ACCESS
  } phase_e;

  // Required time in ns -> whole clock cycles, rounded up, never below one.
  function automatic int unsigned ns_to_cyc(int unsigned t_ns, int unsigned clk_ns);
    int unsigned r;
    r = (t_ns + clk_ns - 1) / clk_ns;
    if (r == 0) r = 1;
    return r;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned N_RD  = 14,
  parameter int unsigned N_PW  = 12,
  parameter int unsigned N_WH  = 1,
  parameter int unsigned N_HZ  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             ph_zero,
  input  logic             turn_zero,
  output phase_e           state,
  output logic             ph_load,
  output logic [CNT_W-1:0] ph_val,
  output logic             turn_load,
  output logic [CNT_W-1:0] turn_val,
  output logic             accept,
  output logic             capture,
  output logic             ack
);

  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(N_RD - 1);
  localparam logic [CNT_W-1:0] PW_LOAD = CNT_W'(N_PW - 1);
  localparam logic [CNT_W-1:0] WH_LOAD = CNT_W'(N_WH - 1);
  localparam logic [CNT_W-1:0] HZ_LOAD = CNT_W'(N_HZ - 1);

  phase_e st_q, st_d;
  logic   ack_q, done;

  always_comb begin
    st_d      = st_q;
    ph_load   = 1'b0;
    ph_val    = '0;
    turn_load = 1'b0;
    turn_val  = '0;
    accept    = 1'b0;
    capture   = 1'b0;
    done      = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid && !ack_q) begin
          if (req_write) begin
            if (turn_zero) begin
              st_d   = ST_WR_SETUP;
              accept = 1'b1;
            end
          end else begin
            st_d    = ST_RD_ACCESS;
            accept  = 1'b1;
            ph_load = 1'b1;
            ph_val  = RD_LOAD;
          end
        end
      end
      ST_WR_SETUP: begin
        st_d    = ST_WR_PULSE;
        ph_load = 1'b1;
        ph_val  = PW_LOAD;
      end
      ST_WR_PULSE: begin
        if (ph_zero) begin
          st_d    = ST_WR_HOLD;
          ph_load = 1'b1;
          ph_val  = WH_LOAD;
        end
      end
      ST_WR_HOLD: begin
        if (ph_zero) begin
          st_d = ST_IDLE;
          done = 1'b1;
        end
      end
      ST_RD_ACCESS: begin
        if (ph_zero) begin
          st_d      = ST_IDLE;
          done      = 1'b1;
          capture   = 1'b1;
          turn_load = 1'b1;
          turn_val  = HZ_LOAD;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ack_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ack_q <= done;
    end
  end

  assign state = st_q;
  assign ack   = ack_q;

endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            state,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdat_q;
  logic [DATA_W-1:0] rdat_q;
  logic              active, in_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wdat_q <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
      wdat_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdat_q <= '0;
    end else if (capture) begin
      rdat_q <= mem_dq_in;
    end
  end

  always_comb begin
    active   = (state != ST_IDLE);
    in_write = (state == ST_WR_SETUP) || (state == ST_WR_PULSE) || (state == ST_WR_HOLD);
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdat_q;
  assign rd_data    = rdat_q;
  assign mem_sel_n  = !active;
  assign mem_sel    = active;
  assign mem_oe_n   = (state != ST_RD_ACCESS);
  assign mem_we_n   = (state != ST_WR_PULSE);
  assign mem_dq_oe  = in_write;

endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned CLK_NS   = 4,
  parameter int unsigned T_RC_NS  = 55,
  parameter int unsigned T_AA_NS  = 55,
  parameter int unsigned T_WC_NS  = 55,
  parameter int unsigned T_AW_NS  = 45,
  parameter int unsigned T_PWE_NS = 40,
  parameter int unsigned T_SD_NS  = 30,
  parameter int unsigned T_HD_NS  = 0,
  parameter int unsigned T_HZ_NS  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int unsigned N_RD = umax(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_RC_NS, CLK_NS));
  localparam int unsigned N_PW = umax(umax(ns_to_cyc(T_PWE_NS, CLK_NS), ns_to_cyc(T_AW_NS, CLK_NS)),
                                      ns_to_cyc(T_SD_NS, CLK_NS));
  localparam int unsigned WC_C = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int unsigned WC_R = (WC_C > N_PW + 1) ? (WC_C - N_PW - 1) : 1;
  localparam int unsigned N_WH = umax(ns_to_cyc(T_HD_NS, CLK_NS), WC_R);
  localparam int unsigned N_HZ = ns_to_cyc(T_HZ_NS, CLK_NS);
  localparam int unsigned CNT_MAX = umax(umax(N_RD, N_PW), umax(N_WH, N_HZ));
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  phase_e           state;
  logic             ph_load, turn_load, ph_zero, turn_zero;
  logic [CNT_W-1:0] ph_val, turn_val;
  logic             accept, capture;

  sram_seq_fsm #(
    .CNT_W (CNT_W),
    .N_RD  (N_RD),
    .N_PW  (N_PW),
    .N_WH  (N_WH),
    .N_HZ  (N_HZ)
  ) fsm_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .ph_zero   (ph_zero),
    .turn_zero (turn_zero),
    .state     (state),
    .ph_load   (ph_load),
    .ph_val    (ph_val),
    .turn_load (turn_load),
    .turn_val  (turn_val),
    .accept    (accept),
    .capture   (capture),
    .ack       (ack)
  );

  sram_cycle_timer #(.CNT_W(CNT_W)) phase_tmr_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (ph_load),
    .load_val (ph_val),
    .zero     (ph_zero)
  );

  sram_cycle_timer #(.CNT_W(CNT_W)) turn_tmr_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (turn_load),
    .load_val (turn_val),
    .zero     (turn_zero)
  );

  sram_pin_drive #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) pins_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .state      (state),
    .accept     (accept),
    .capture    (capture),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_dq_in  (mem_dq_in),
    .rd_data    (rd_data),
    .mem_addr   (mem_addr),
    .mem_sel_n  (mem_sel_n),
    .mem_sel    (mem_sel),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
  );

endmodule

// File: rtl/sram_port_ctrl_chk.sv
module sram_port_ctrl_chk #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned HZ_CYC = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_sel_n,
  input logic              mem_sel,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe
);

  localparam int unsigned GAP_W = $clog2(HZ_CYC + 1) + 1;
  localparam logic [GAP_W-1:0] GAP_LIM = GAP_W'(HZ_CYC);

  // Cycles since the memory was last asked to drive the bus.
  logic [GAP_W-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '1;
    end else if (!mem_oe_n) begin
      gap_q <= '0;
    end else if (gap_q != '1) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  assert_no_drive_in_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);

  assert_oe_off_in_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  assert_we_needs_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_sel_n && mem_sel));

  assert_ack_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  assert_ack_deselected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (mem_sel_n && !mem_sel));

  assert_addr_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_sel_n && $past(!mem_sel_n)) |-> $stable(mem_addr));

  assert_turnaround_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (gap_q >= GAP_LIM));

endmodule

bind sram_port_ctrl sram_port_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .HZ_CYC (N_HZ)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ack       (ack),
  .mem_addr  (mem_addr),
  .mem_sel_n (mem_sel_n),
  .mem_sel   (mem_sel),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_port_ctrl_tb_top.sv
module sram_port_ctrl_tb_top;

  localparam int CLK_NS = 4;
  localparam int T_RC = 55, T_AA = 55, T_WC = 80, T_AW = 45, T_PWE = 40;
  localparam int T_SD = 30, T_HD = 0, T_HZ = 20;

  function automatic int cyc(int t);
    int r;
    r = (t + CLK_NS - 1) / CLK_NS;
    return (r < 1) ? 1 : r;
  endfunction
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_RD = mx(cyc(T_AA), cyc(T_RC));
  localparam int E_PW = mx(mx(cyc(T_PWE), cyc(T_AW)), cyc(T_SD));
  localparam int E_WH = mx(cyc(T_HD), cyc(T_WC) - 1 - E_PW);
  localparam int E_HZ = cyc(T_HZ);

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [19:0] req_addr;
  logic [7:0]  req_wdata;
  logic        ack;
  logic [7:0]  rd_data;
  logic [19:0] mem_addr;
  logic        mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  dq_in_r = 8'hC3;

  always #2 clk = ~clk;

  sram_port_ctrl #(.CLK_NS(CLK_NS), .T_WC_NS(T_WC)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(dq_in_r)
  );

  int n_chk = 0, n_err = 0;
  int edge_n = 0;
  bit finished = 0;
  always @(posedge clk) edge_n++;

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  // Expected pin states, one entry per sampled cycle
  typedef struct packed { logic sel; logic rd; logic wp; logic drv; logic ack; } exp_t;
  exp_t  expq[$];
  string tagq[$];
  logic [19:0] cur_addr;
  logic [7:0]  cur_data;
  int  last_done = -100;
  bit  last_rd = 0;

  logic [7:0] mem_arr [int];
  logic [7:0] shadow  [int];

  task automatic push(exp_t e, string tag, int n);
    for (int i = 0; i < n; i++) begin
      expq.push_back(e);
      tagq.push_back(tag);
    end
  endtask

  // Behavioural memory: timing monitor and data source
  int rd_cnt = 0, tail = 0, we_cnt = 0, sel_cnt = 0, addr_cnt = 0, dat_cnt = 0;
  int w_addr_snap = 0, w_dat_snap = 0;
  bit p_sel = 0, p_wr = 0, p_drv = 0, win_wr = 0;
  logic [19:0] p_addr = '0;
  logic [7:0]  p_dq = '0;

  task automatic mem_model();
    bit sel, rd, wr;
    sel = !mem_sel_n && mem_sel;
    rd  = sel && !mem_oe_n && mem_we_n;
    wr  = sel && !mem_we_n;
    if (sel) begin
      sel_cnt  = p_sel ? sel_cnt + 1 : 1;
      addr_cnt = (p_sel && mem_addr == p_addr) ? addr_cnt + 1 : 1;
    end
    dat_cnt = !mem_dq_oe ? 0 : ((p_drv && mem_dq_out == p_dq) ? dat_cnt + 1 : 1);
    if (p_wr && !wr) begin
      check(we_cnt * CLK_NS >= T_PWE, "R5", "write pulse ns", we_cnt * CLK_NS, T_PWE);
      check(w_addr_snap * CLK_NS >= T_AW, "R5", "address to write end ns", w_addr_snap * CLK_NS, T_AW);
      check(w_dat_snap * CLK_NS >= T_SD, "R6", "data setup ns", w_dat_snap * CLK_NS, T_SD);
      check(mem_dq_oe && mem_dq_out == p_dq && mem_addr == p_addr, "R6", "data hold at write end",
            {mem_dq_oe, mem_dq_out}, {1'b1, p_dq});
      mem_arr[int'(p_addr)] = p_dq;
      win_wr = 1;
    end
    if (wr) begin
      we_cnt      = p_wr ? we_cnt + 1 : 1;
      w_addr_snap = addr_cnt;
      w_dat_snap  = dat_cnt;
      if (!mem_oe_n) check(0, "R6", "output enable low during write", 0, 1);
    end
    if (p_sel && !sel) begin
      if (win_wr) check(sel_cnt * CLK_NS >= T_WC, "R7", "write cycle ns", sel_cnt * CLK_NS, T_WC);
      else        check(sel_cnt * CLK_NS >= T_RC, "R3", "read cycle ns", sel_cnt * CLK_NS, T_RC);
      win_wr = 0;
    end
    if (rd) begin
      rd_cnt++;
      tail = E_HZ;
      if (mem_dq_oe) check(0, "R6", "bus contention in read", 1, 0);
      dq_in_r = (rd_cnt >= cyc(T_AA)) ? (mem_arr.exists(int'(mem_addr)) ? mem_arr[int'(mem_addr)] : 8'h00)
                                      : 8'h5A;
    end else begin
      rd_cnt = 0;
      if (tail > 0) begin
        if (mem_dq_oe) check(0, "R9", "drive while memory releases bus", 1, 0);
        tail--;
      end
      dq_in_r = 8'hC3;
    end
    p_sel = sel; p_wr = wr; p_drv = mem_dq_oe; p_addr = mem_addr; p_dq = mem_dq_out;
  endtask

  task automatic compare();
    exp_t e;
    string tg;
    logic [5:0] act, ex;
    if (expq.size() > 0) begin
      e  = expq.pop_front();
      tg = tagq.pop_front();
    end else begin
      e  = '0;
      tg = "R2";
    end
    act = {~mem_sel_n, mem_sel, ~mem_oe_n, ~mem_we_n, mem_dq_oe, ack};
    ex  = {e.sel, e.sel, e.rd, e.wp, e.drv, e.ack};
    check(act == ex, tg, "pins {sel,sel,oe,we,drv,ack}", act, ex);
    if (e.sel) check(mem_addr == cur_addr, "R10", "address", mem_addr, cur_addr);
    if (e.drv) check(mem_dq_out == cur_data, "R6", "write data", mem_dq_out, cur_data);
  endtask

  task automatic tick();
    @(negedge clk);
    mem_model();
    compare();
  endtask

  task automatic do_write(logic [19:0] a, logic [7:0] d);
    int x, acc;
    x = edge_n + 1;
    acc = mx(x, last_done + 2);
    if (last_rd) acc = mx(acc, last_done + E_HZ);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    cur_addr = a; cur_data = d;
    push('0, "R9", acc - x);
    push(5'b10010, "R5", 1);
    push(5'b10110, "R11", E_PW);
    push(5'b10010, "R7", E_WH);
    push(5'b00001, "R8", 1);
    repeat ((acc - x) + 1 + E_PW + E_WH + 1) tick();
    req_valid = 0;
    last_done = acc + 1 + E_PW + E_WH;
    last_rd = 0;
    shadow[int'(a)] = d;
  endtask

  task automatic do_read(logic [19:0] a);
    int x, acc;
    logic [7:0] exp_d;
    x = edge_n + 1;
    acc = mx(x, last_done + 2);
    req_valid = 1; req_write = 0; req_addr = a; req_wdata = 8'hEE;
    cur_addr = a;
    push('0, "R8", acc - x);
    push(5'b11000, "R3", E_RD);
    push(5'b00001, "R8", 1);
    repeat ((acc - x) + E_RD + 1) tick();
    req_valid = 0;
    exp_d = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
    check(rd_data == exp_d, "R4", "read data", rd_data, exp_d);
    last_done = acc + E_RD;
    last_rd = 1;
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    cur_addr = '0; cur_data = '0;
    repeat (3) tick();
    check({mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe, ack} == 6'b101100, "R1",
          "reset pins", {mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe, ack}, 6'b101100);
    rst_n = 1;
    repeat (5) tick();
    do_write(20'h00012, 8'h3C);
    do_read(20'h00012);                    // read right after write
    do_write(20'h00013, 8'hA5);            // write right after read: turnaround
    do_write(20'hFFFFF, 8'hFF);            // back-to-back writes
    do_write(20'h00000, 8'h00);
    do_read(20'hFFFFF);
    do_read(20'h00000);                    // back-to-back reads
    do_read(20'h54321);                    // never written
    repeat (7) tick();                     // idle gap, standby
    do_write(20'h00012, 8'hC7);            // overwrite
    do_read(20'h00012);
    repeat (2) tick();
    do_write(20'h80001, 8'h5A);            // write after idle read gap
    do_read(20'h80001);
    do_read(20'h00013);
    repeat (4) tick();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(200000 * CLK_NS);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule